// File: doc/BRIEF.md
# DRP Read-Modify-Write Reconfiguration Sequencer

This block reprograms a clock-synthesis macro through its dynamic reconfiguration port. A table of entries, fixed by a parameter, holds two configuration sets placed back to back. Each entry has a 7-bit register address, a 16-bit keep-mask and 16 set-bits. When the user starts a sequence, the block walks the selected set in order. For each entry it reads the register, keeps only the bits the mask allows, ORs in the set-bits and writes the result back to the same address.

For the whole sequence, from the first write until the last write is acknowledged, the block holds the clock macro in reset. Once the sequence is done, the block waits for the macro to report lock again. It then pulses a one-cycle ready flag, and the next sequence may be started. Every port access waits for the port's acknowledge, so the read or write latency of the target can vary.

Top module: `drp_reconfig_seq`

## Requirements
- R1: While `rst` is high, `pllRst` is high, `drpEn`, `drpWe` and `cfgReady` are low, and no port access is issued. After `rst` falls, the block waits for lock before it accepts a start.
- R2: `cfgReady` goes high for exactly one clock when lock is seen after reset or after a finished sequence, and only while `pllLocked` is high.
- R3: `cfgStart` is acted on only in the idle state that follows a `cfgReady` pulse. A start raised while the block waits for lock, or during a sequence, causes no port access.
- R4: `cfgSel`=0 walks table entries 0 to SET_LEN-1, and `cfgSel`=1 walks entries SET_LEN to 2*SET_LEN-1, in ascending order. Entry i sits at bits [i*39 +: 39] of `ROM_INIT` as {address[6:0], mask[15:0], set-bits[15:0]}.
- R5: For each entry the block issues one read (`drpEn` high, `drpWe` low) to the entry's address, then one write (`drpEn` and `drpWe` high together) to the same address. Each strobe lasts one clock.
- R6: The written word equals (word read AND mask) OR set-bits. Bits with a mask of 1 and a set-bit of 0 keep their old value.
- R7: No new access is issued until `drpRdy` has acknowledged the previous one, whatever the latency.
- R8: `pllRst` goes high with the first write and stays high until the last write is acknowledged, then it falls.
- R9: `drpClk` is `sclk` passed through with no register.
- R10: A sequence makes exactly 2*SET_LEN port accesses (SET_LEN reads, SET_LEN writes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgSel | input | 1 | Configuration set chosen at start |
| cfgStart | input | 1 | Start request, sampled on the rising edge |
| cfgReady | output | 1 | One-cycle pulse: idle and locked |
| pllLocked | input | 1 | Lock indication from the clock macro |
| pllRst | output | 1 | Reset to the clock macro |
| drpClk | output | 1 | Port clock, equal to `sclk` |
| drpAddr | output | 7 | Port register address |
| drpWrData | output | 16 | Port write data |
| drpRdData | input | 16 | Port read data |
| drpEn | output | 1 | Port access strobe |
| drpWe | output | 1 | Port write qualifier |
| drpRdy | input | 1 | Port access acknowledge |

## Verification
The embedded assertions watch the following on every cycle:
- the strobes are single-cycle;
- a write always comes with an enable;
- the ready flag never lasts two clocks;
- the macro reset is high after a write;
- no strobe is issued while an access is still unacknowledged;
- the merged word clears every bit the mask drops and holds every set-bit.

Some behaviour can be shown only by the bench scenarios, which use a register-file model with random latency and a lock model:
- the order and addresses of a whole sequence for each set;
- the exact values written against a snapshot of the registers;
- that reserved bits survive;
- that starts during lock-wait or mid-sequence are ignored;
- recovery after a reset in mid-sequence.

// File: rtl/drp_seq_pkg.sv
package drp_seq_pkg;

  localparam int DRP_AW  = 7;
  localparam int DRP_DW  = 16;
  localparam int ENTRY_W = DRP_AW + 2 * DRP_DW;

  // Default table entry: power register, every bit forced high.
  localparam logic [ENTRY_W-1:0] DEF_ENTRY = {7'h28, 16'h0000, 16'hFFFF};

  typedef struct packed {
    logic [DRP_AW-1:0] addr;
    logic [DRP_DW-1:0] mask;
    logic [DRP_DW-1:0] bits;
  } romEntry_t;

  typedef struct packed {
    logic loadIdx;
    logic stepIdx;
    logic capture;
    logic applyMask;
    logic applySet;
  } dpCtrl_t;

  typedef enum logic [3:0] {
    ST_RESTART   = 4'd0,
    ST_WAIT_LOCK = 4'd1,
    ST_IDLE      = 4'd2,
    ST_ADDR      = 4'd3,
    ST_RD_WAIT   = 4'd4,
    ST_MASK      = 4'd5,
    ST_SET       = 4'd6,
    ST_WRITE     = 4'd7,
    ST_WR_WAIT   = 4'd8
  } seqState_t;

endpackage

// File: rtl/drp_seq_dpath.sv
module drp_seq_dpath
  import drp_seq_pkg::*;
#(
  parameter int SET_LEN = 4,
  parameter logic [2*SET_LEN*ENTRY_W-1:0] ROM_INIT = {(2*SET_LEN){DEF_ENTRY}}
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtrl_t           ctrl,
  input  logic              cfgSel,
  input  logic [DRP_DW-1:0] drpRdData,
  output logic [DRP_AW-1:0] drpAddr,
  output logic [DRP_DW-1:0] drpWrData
);

  localparam int ROM_DEPTH = 2 * SET_LEN;
  localparam int IDX_W     = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1;

  romEntry_t         rom [ROM_DEPTH];
  logic [IDX_W-1:0]  idx;
  romEntry_t         cur;
  logic [DRP_DW-1:0] wrData;

  for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_rom
    assign rom[g] = romEntry_t'(ROM_INIT[g*ENTRY_W +: ENTRY_W]);
  end

  assign cur = rom[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (ctrl.loadIdx) begin
      idx <= cfgSel ? IDX_W'(SET_LEN) : '0;
    end else if (ctrl.stepIdx) begin
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrData <= '0;
    end else if (ctrl.capture) begin
      wrData <= drpRdData;
    end else if (ctrl.applyMask) begin
      wrData <= wrData & cur.mask;
    end else if (ctrl.applySet) begin
      wrData <= wrData | cur.bits;
    end
  end

  assign drpAddr   = cur.addr;
  assign drpWrData = wrData;

  // R6: after masking no dropped bit remains set
  assert_mask_clears_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl.applyMask |=> ((drpWrData & ~cur.mask) == '0));

  // R6: after the set step every set-bit is present
  assert_bits_present_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl.applySet |=> ((drpWrData & cur.bits) == cur.bits));

endmodule

// File: rtl/drp_seq_ctrl.sv
module drp_seq_ctrl
  import drp_seq_pkg::*;
#(
  parameter int SET_LEN = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    cfgStart,
  input  logic    drpRdy,
  input  logic    pllLocked,
  output dpCtrl_t ctrl,
  output logic    drpEn,
  output logic    drpWe,
  output logic    cfgReady,
  output logic    pllRst
);

  localparam int CNT_W = $clog2(SET_LEN + 1);

  seqState_t        state, stateNext;
  logic [CNT_W-1:0] left;
  logic             rstHold;
  logic             readyQ;
  logic             startOk;
  logic             lastDone;

  assign startOk  = (state == ST_IDLE) && cfgStart;
  assign lastDone = (state == ST_WR_WAIT) && drpRdy && (left == '0);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RESTART:   stateNext = ST_WAIT_LOCK;
      ST_WAIT_LOCK: if (pllLocked) stateNext = ST_IDLE;
      ST_IDLE:      if (cfgStart) stateNext = ST_ADDR;
      ST_ADDR:      stateNext = ST_RD_WAIT;
      ST_RD_WAIT:   if (drpRdy) stateNext = ST_MASK;
      ST_MASK:      stateNext = ST_SET;
      ST_SET:       stateNext = ST_WRITE;
      ST_WRITE:     stateNext = ST_WR_WAIT;
      ST_WR_WAIT:   if (drpRdy) stateNext = (left != '0) ? ST_ADDR : ST_WAIT_LOCK;
      default:      stateNext = ST_RESTART;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_RESTART;
      left    <= '0;
      rstHold <= 1'b0;
      readyQ  <= 1'b0;
    end else begin
      state  <= stateNext;
      readyQ <= (state == ST_WAIT_LOCK) && pllLocked;
      if (startOk) begin
        left <= CNT_W'(SET_LEN);
      end else if (state == ST_WRITE) begin
        left <= left - 1'b1;
      end
      if (state == ST_WRITE) begin
        rstHold <= 1'b1;
      end else if (lastDone) begin
        rstHold <= 1'b0;
      end
    end
  end

  always_comb begin
    ctrl           = '0;
    ctrl.loadIdx   = startOk;
    ctrl.stepIdx   = (state == ST_WRITE);
    ctrl.capture   = (state == ST_RD_WAIT) && drpRdy;
    ctrl.applyMask = (state == ST_MASK);
    ctrl.applySet  = (state == ST_SET);
  end

  assign drpEn    = (state == ST_ADDR) || (state == ST_WRITE);
  assign drpWe    = (state == ST_WRITE);
  assign cfgReady = readyQ;
  assign pllRst   = rst | rstHold;

  assert_we_needs_en_R5: assert property (@(posedge clk) disable iff (rst)
    drpWe |-> drpEn);

  assert_en_single_R5: assert property (@(posedge clk) disable iff (rst)
    drpEn |=> !drpEn);

  assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    cfgReady |=> !cfgReady);

  assert_rst_after_write_R8: assert property (@(posedge clk) disable iff (rst)
    drpWe |=> pllRst);

  assert_no_issue_pending_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD_WAIT && !drpRdy) |=> !drpEn);

endmodule

// File: rtl/drp_reconfig_seq.sv
module drp_reconfig_seq
  import drp_seq_pkg::*;
#(
  parameter int SET_LEN = 4,
  parameter logic [2*SET_LEN*ENTRY_W-1:0] ROM_INIT = {(2*SET_LEN){DEF_ENTRY}}
) (
  input  logic              sclk,
  input  logic              rst,
  input  logic              cfgSel,
  input  logic              cfgStart,
  output logic              cfgReady,
  input  logic              pllLocked,
  output logic              pllRst,
  output logic              drpClk,
  output logic [DRP_AW-1:0] drpAddr,
  output logic [DRP_DW-1:0] drpWrData,
  input  logic [DRP_DW-1:0] drpRdData,
  output logic              drpEn,
  output logic              drpWe,
  input  logic              drpRdy
);

  dpCtrl_t ctrl;

  assign drpClk = sclk;

  drp_seq_ctrl #(.SET_LEN(SET_LEN)) u_ctrl (
    .clk       (sclk),
    .rst       (rst),
    .cfgStart  (cfgStart),
    .drpRdy    (drpRdy),
    .pllLocked (pllLocked),
    .ctrl      (ctrl),
    .drpEn     (drpEn),
    .drpWe     (drpWe),
    .cfgReady  (cfgReady),
    .pllRst    (pllRst)
  );

  drp_seq_dpath #(.SET_LEN(SET_LEN), .ROM_INIT(ROM_INIT)) u_dpath (
    .clk       (sclk),
    .rst       (rst),
    .ctrl      (ctrl),
    .cfgSel    (cfgSel),
    .drpRdData (drpRdData),
    .drpAddr   (drpAddr),
    .drpWrData (drpWrData)
  );

endmodule

// File: tb/drp_reconfig_seq_test.sv
`timescale 1ns/1ps
module drp_reconfig_seq_test;

  localparam int SL = 4;
  localparam int LOCK_DLY = 5;

  // {address, mask, set-bits}; set 1 then set 2
  localparam logic [38:0] TB_TAB [8] = '{
    {7'h08, 16'h1000, 16'h4083},
    {7'h09, 16'hFC00, 16'h0041},
    {7'h28, 16'h0000, 16'hFFFF},
    {7'h4E, 16'h6600, 16'h8900},
    {7'h08, 16'h1000, 16'h2145},
    {7'h09, 16'hFC00, 16'h0080},
    {7'h28, 16'h0000, 16'hFFFF},
    {7'h4F, 16'h666F, 16'h9990}
  };
  localparam logic [2*SL*39-1:0] TB_ROM = {TB_TAB[7], TB_TAB[6], TB_TAB[5], TB_TAB[4],
                                           TB_TAB[3], TB_TAB[2], TB_TAB[1], TB_TAB[0]};
  // run vectors: bit1 = extra start mid-sequence, bit0 = set select
  localparam logic [1:0] RUNS [4] = '{2'b00, 2'b01, 2'b11, 2'b00};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgSel = 1'b0, cfgStart = 1'b0, cfgReady;
  logic pllLocked = 1'b0, pllRst, drpClk;
  logic [6:0] drpAddr;
  logic [15:0] drpWrData, drpRdData;
  logic drpEn, drpWe, drpRdy;

  always #2 clk = ~clk;

  drp_reconfig_seq #(.SET_LEN(SL), .ROM_INIT(TB_ROM)) uut (
    .sclk(clk), .rst(rst), .cfgSel(cfgSel), .cfgStart(cfgStart), .cfgReady(cfgReady),
    .pllLocked(pllLocked), .pllRst(pllRst), .drpClk(drpClk), .drpAddr(drpAddr),
    .drpWrData(drpWrData), .drpRdData(drpRdData), .drpEn(drpEn), .drpWe(drpWe),
    .drpRdy(drpRdy)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [15:0] mem [128];
  logic [6:0]  logA [64];
  logic        logW [64];
  logic [15:0] logD [64];
  int logCnt = 0;
  int readyCnt = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishUp();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  endtask

  // behavioural register file with random acknowledge latency
  initial begin
    int cnt;
    logic [6:0] curA;
    logic curW;
    logic [15:0] curD;
    cnt = 0; curA = '0; curW = 0; curD = '0;
    drpRdy = 1'b0;
    drpRdData = '0;
    for (int i = 0; i < 128; i++) mem[i] = 16'hA5C3 ^ 16'(i * 16'h1357);
    forever begin
      @(negedge clk);
      drpRdy = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          drpRdy = 1'b1;
          if (curW) begin
            mem[curA] = curD;
            chk(pllRst === 1'b1, "R8 reset held at write ack", 32'(pllRst), 1);
          end else begin
            drpRdData = mem[curA];
          end
        end
      end
      if (drpEn === 1'b1) begin
        chk(cnt == 0, "R7 access before ack", cnt, 0);
        curA = drpAddr; curW = drpWe; curD = drpWrData;
        if (logCnt < 64) begin
          logA[logCnt] = drpAddr; logW[logCnt] = drpWe; logD[logCnt] = drpWrData;
          logCnt++;
        end
        cnt = $urandom_range(4, 1);
      end
    end
  end

  // lock model: drops under reset, returns LOCK_DLY cycles after release
  initial begin
    int lockCnt;
    lockCnt = 0;
    forever begin
      @(negedge clk);
      if (pllRst === 1'b1) begin
        lockCnt = 0;
        pllLocked = 1'b0;
      end else if (lockCnt < LOCK_DLY) begin
        lockCnt++;
      end else begin
        pllLocked = 1'b1;
      end
    end
  end

  // ready-pulse monitor
  initial begin
    logic prevReady;
    prevReady = 1'b0;
    forever begin
      @(negedge clk);
      if (cfgReady === 1'b1) begin
        readyCnt++;
        chk(prevReady == 1'b0, "R2 ready longer than one cycle", 1, 0);
        chk(pllLocked == 1'b1, "R2 ready without lock", 32'(pllLocked), 1);
      end
      prevReady = cfgReady;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finishUp();
  end

  task automatic waitReady(int r0);
    int n;
    n = 0;
    while (readyCnt <= r0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(readyCnt > r0, "R2 ready pulse seen", readyCnt, r0 + 1);
  endtask

  task automatic runSeq(logic sel, logic extraStart);
    logic [15:0] snap [128];
    int r0;
    for (int i = 0; i < 128; i++) snap[i] = mem[i];
    r0 = readyCnt;
    logCnt = 0;
    @(negedge clk);
    cfgSel = sel;
    cfgStart = 1'b1;
    @(negedge clk);
    cfgStart = 1'b0;
    if (extraStart) begin
      while (logCnt < 2) @(negedge clk);
      cfgStart = 1'b1;
      @(negedge clk);
      cfgStart = 1'b0;
    end
    waitReady(r0);
    chk(logCnt == 2 * SL, "R10 access count", logCnt, 2 * SL);
    for (int k = 0; k < SL; k++) begin
      logic [38:0] e;
      logic [6:0] a;
      logic [15:0] expD;
      e = TB_TAB[sel * SL + k];
      a = e[38:32];
      expD = (snap[a] & e[31:16]) | e[15:0];
      chk(logA[2*k] == a && !logW[2*k], "R4 read address/order", logA[2*k], a);
      chk(logA[2*k+1] == a && logW[2*k+1], "R5 write follows read", logA[2*k+1], a);
      chk(logD[2*k+1] == expD, "R6 merged write data", logD[2*k+1], expD);
    end
    chk(pllRst == 1'b0, "R8 reset released after sequence", 32'(pllRst), 0);
  endtask

  initial begin
    int r0;
    repeat (5) @(negedge clk);
    chk(pllRst == 1'b1, "R1 pllRst in reset", 32'(pllRst), 1);
    chk(drpEn == 1'b0 && drpWe == 1'b0, "R1 no strobe in reset", {drpEn, drpWe}, 0);
    chk(cfgReady == 1'b0, "R1 no ready in reset", 32'(cfgReady), 0);
    chk(drpClk == clk, "R9 drpClk low phase", 32'(drpClk), 32'(clk));
    @(posedge clk);
    #1;
    chk(drpClk == 1'b1, "R9 drpClk high phase", 32'(drpClk), 1);

    // R3: start while waiting for lock is ignored
    @(negedge clk);
    r0 = readyCnt;
    logCnt = 0;
    rst = 1'b0;
    cfgStart = 1'b1;
    repeat (3) @(negedge clk);
    cfgStart = 1'b0;
    waitReady(r0);
    repeat (10) @(negedge clk);
    chk(logCnt == 0, "R3 start during lock wait ignored", logCnt, 0);

    // table of runs
    for (int r = 0; r < 4; r++) begin
      runSeq(RUNS[r][0], RUNS[r][1]);
      if (RUNS[r][1]) begin
        repeat (20) @(negedge clk);
        chk(logCnt == 2 * SL, "R3 start during sequence ignored", logCnt, 2 * SL);
      end
    end

    // R1: reset in mid-sequence, then recovery
    r0 = readyCnt;
    logCnt = 0;
    cfgSel = 1'b1;
    cfgStart = 1'b1;
    @(negedge clk);
    cfgStart = 1'b0;
    while (logCnt < 3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(pllRst == 1'b1, "R1 pllRst on mid-sequence reset", 32'(pllRst), 1);
    chk(drpEn == 1'b0, "R1 no access under reset", 32'(drpEn), 0);
    rst = 1'b0;
    waitReady(r0);
    runSeq(1'b0, 1'b0);

    finishUp();
  end

endmodule